// File: doc/BRIEF.md
# Frame Period Meter

This block measures the time between successive vertical sync pulses. It counts the ticks of a fixed timebase, one tick every 8 µs by default, from one rising edge of the sync input to the next. At each rising edge it captures the count into a register pair, together with a flag that marks the count as invalid, and then starts counting again from zero. Firmware reads the result through a small register port, with a read strobe, an address bit and a combinational data bus. The port also holds a 2-bit clamp-width field, which drives the `clamp_width` output.

The count is 13 bits wide. A capture puts the upper count bits straight into the high register. The lower 8 bits go to a hidden holding byte. A read of the high register moves the holding byte into the low register. Firmware must therefore read high and then low. The two bytes it gets always belong to the same frame, even when a new capture lands between the two reads.

The measurement is run by a three-state sequencer:
- `ST_IDLE`: no reference edge has been seen since reset. The first rising edge moves it to `ST_RUN` and captures nothing.
- `ST_RUN`: counting. A rising edge captures the count and stays in `ST_RUN`. A tick that arrives at the maximum count moves it to `ST_SAT`.
- `ST_SAT`: the counter has overflowed and holds at all ones. A rising edge captures the count with the flag set and returns to `ST_RUN`.

Top module: `frame_period_meter`

## Requirements
- R1: After reset, the high register, the low register and `clamp_width` all read zero.
- R2: The prescaler is cleared at each detected sync rising edge and then gives one tick every TICK_DIV clocks. The captured count is therefore floor((D-1)/TICK_DIV), where D is the number of clocks between two rising edges of `vsync`.
- R3: `vsync` passes through a two-flop synchroniser. Only its low-to-high transitions start or end a measurement; the time the input stays high does not change the result.
- R4: The first rising edge after reset only starts counting. It captures nothing, so both registers still read zero afterwards.
- R5: The high register (address 0) reads as follows: bit 7 is the overflow flag, bits 6:5 are 0 and bits 4:0 are count bits 12:8. A capture updates the high register at once. Count bits 7:0 go to the holding byte only.
- R6: A read of address 0 copies the holding byte into the low register (address 1). Reads of address 1 return the byte copied by the most recent high read, and have no side effect.
- R7: If the count would pass 8191, it holds at 8191 and the next capture sets the overflow flag. A later frame that does not overflow clears the flag.
- R8: A write to address 0 loads `wr_data[6:5]` into `clamp_width` (bit 6 is the MSB). All other written bits are ignored and the high register's contents do not change.
- R9: Writes to address 1 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Asynchronous vertical sync input |
| addr | input | 1 | Register select: 0 high, 1 low |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| clamp_width | output | 2 | Clamp pulse width selection |

## Verification
A fault in the sequencer or the counter shows up as a wrong byte pair on the first high/low read after the next rising edge, so one frame plus a few cycles is enough to expose it. Frame lengths are chosen on both sides of the 8-bit carry and of the saturation limit, where a wrapping counter or a lost flag would give a different high byte. A fault in the holding byte shows up when the low register is read out of order: the read either returns the new frame's byte too early or stays stale after a high read. That is visible within one access.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SAT  = 2'd2
    } meter_state_t;

    localparam logic ADDR_HI = 1'b0;
    localparam logic ADDR_LO = 1'b1;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/fpm_tick_gen.sv
module fpm_tick_gen #(
    parameter int TICK_DIV = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          div_q <= '0;
        else if (clear)      div_q <= '0;
        else if (tick)       div_q <= '0;
        else                 div_q <= div_q + 1'b1;
    end

    generate
        if (TICK_DIV > 1) begin : g_spacing
            // R2: ticks are never back to back when dividing
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/fpm_edge_sync.sv
module fpm_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], async_in};
    end

    assign rise = sh_q[1] & ~sh_q[2];

    // R3: a detected edge is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/fpm_period_meter.sv
module fpm_period_meter
    import fpm_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rise,
    output logic             cap_valid,
    output logic [CNT_W-1:0] cap_cnt,
    output logic             cap_ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meter_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_max;

    assign at_max = (cnt_q == CNT_MAX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rise) state_d = ST_RUN;
            ST_RUN: begin
                if (rise)                state_d = ST_RUN;
                else if (tick && at_max) state_d = ST_SAT;
            end
            ST_SAT:  if (rise) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (rise)
            cnt_q <= '0;
        else if (state_q == ST_RUN && tick && !at_max)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        cap_valid = rise && (state_q != ST_IDLE);
        cap_cnt   = cnt_q;
        cap_ovf   = (state_q == ST_SAT);
    end

    // R2: counter restarts after every detected edge
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cnt_q == '0));
    // R4: nothing is counted before the first reference edge
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cnt_q == '0 && !cap_valid));
    // R7: saturated count holds until the next edge
    a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAT && !rise) |=> (cnt_q == CNT_MAX && state_q == ST_SAT));

endmodule

// File: rtl/fpm_regs.sv
module fpm_regs
    import fpm_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [CNT_W-1:0]  cap_cnt,
    input  logic              cap_ovf,
    input  logic              addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [1:0]        clamp_width
);
    localparam int HI_W = CNT_W - BYTE_W;
    localparam int PAD  = BYTE_W - 1 - HI_W;

    logic              vof_q;
    logic [HI_W-1:0]   hi_cnt_q;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] lo_q;
    logic [1:0]        cpw_q;
    logic              rd_hi, wr_hi;
    logic              unused_wr_bits;

    assign rd_hi = rd_en && (addr == ADDR_HI);
    assign wr_hi = wr_en && (addr == ADDR_HI);
    assign unused_wr_bits = ^{wr_data[7], wr_data[4:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vof_q    <= 1'b0;
            hi_cnt_q <= '0;
            hold_q   <= '0;
        end else if (cap_valid) begin
            vof_q    <= cap_ovf;
            hi_cnt_q <= cap_cnt[CNT_W-1:BYTE_W];
            hold_q   <= cap_cnt[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lo_q <= '0;
        else if (rd_hi) lo_q <= hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cpw_q <= '0;
        else if (wr_hi) cpw_q <= wr_data[6:5];
    end

    assign rd_data     = (addr == ADDR_HI) ? {vof_q, {PAD{1'b0}}, hi_cnt_q} : lo_q;
    assign clamp_width = cpw_q;

    // R5: a capture lands in the high register on the next cycle
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> (hi_cnt_q == $past(cap_cnt[CNT_W-1:BYTE_W]) && vof_q == $past(cap_ovf)));
    // R6: the low register only moves on a high read
    a_r6_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hi |=> $stable(lo_q));
    // R8, R9: clamp field only changes on a high write
    a_r8_cpw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(cpw_q));

endmodule

// File: rtl/frame_period_meter.sv
module frame_period_meter #(
    parameter int TICK_DIV = 1600,
    parameter int CNT_W    = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync,
    input  logic       addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [1:0] clamp_width
);
    logic             rise;
    logic             tick;
    logic             cap_valid;
    logic             cap_ovf;
    logic [CNT_W-1:0] cap_cnt;

    fpm_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (vsync),
        .rise     (rise)
    );

    fpm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rise),
        .tick  (tick)
    );

    fpm_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rise      (rise),
        .cap_valid (cap_valid),
        .cap_cnt   (cap_cnt),
        .cap_ovf   (cap_ovf)
    );

    fpm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_valid   (cap_valid),
        .cap_cnt     (cap_cnt),
        .cap_ovf     (cap_ovf),
        .addr        (addr),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .clamp_width (clamp_width)
    );

    // R1: the clamp field can never leave reset non-zero
    a_r1_reset_clamp: assert property (@(posedge clk) $rose(rst_n) |-> (clamp_width == 2'b00));

endmodule

// File: tb/sim_frame_period_meter.sv
`timescale 1ns/1ps
module sim_frame_period_meter;
    localparam int DIV = 2;
    localparam int NV  = 9;
    localparam int GAP  [NV] = '{20, 21, 22, 200, 511, 513, 16383, 16385, 40};
    localparam int HLEN [NV] = '{3,  3,  12, 3,   3,   3,   3,     3,     3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync = 1'b0;
    logic       addr = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] clamp_width;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] last_lo = 8'h00;

    always #2.5 clk = ~clk;

    frame_period_meter #(.TICK_DIV(DIV), .CNT_W(13)) u0 (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .clamp_width(clamp_width)
    );

    function automatic int exp_cnt(int gap);
        int c = (gap - 1) / DIV;
        return (c > 8191) ? 8191 : c;
    endfunction

    function automatic logic exp_ovf(int gap);
        return ((gap - 1) / DIV) > 8191;
    endfunction

    task automatic check(string rq, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One frame: rising edge now, next rising edge gap cycles later (next call).
    task automatic frame(int gap, int hlen, int cnt, logic ovf, string rq);
        logic [7:0] h, l;
        logic [7:0] eh, el;
        vsync = 1'b1;
        repeat (hlen) @(negedge clk);
        vsync = 1'b0;
        repeat (5) @(negedge clk);
        eh = {ovf, 2'b00, 5'(cnt >> 8)};
        el = 8'(cnt);
        rd(1'b0, h);
        rd(1'b1, l);
        check(rq, h, eh);
        check(rq, l, el);
        last_lo = el;
        repeat (gap - hlen - 7) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        string rq;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", clamp_width, 8'h00);
        rd(1'b0, d); check("R1", d, 8'h00);
        rd(1'b1, d); check("R1", d, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: first edge captures nothing
        frame(GAP[0], HLEN[0], 0, 1'b0, "R4");
        for (int i = 1; i < NV; i++) begin
            if (exp_ovf(GAP[i-1]))               rq = "R7";
            else if (GAP[i-1] == 511 || GAP[i-1] == 513) rq = "R5";
            else if (HLEN[i-1] > 3)              rq = "R3";
            else                                 rq = "R2";
            frame(GAP[i], HLEN[i], exp_cnt(GAP[i-1]), exp_ovf(GAP[i-1]), rq);
        end
        // R7: a normal frame after overflow clears the flag
        frame(30, 3, exp_cnt(GAP[NV-1]), 1'b0, "R7");

        // capture the 30-cycle frame without reading high first
        vsync = 1'b1;
        repeat (3) @(negedge clk);
        vsync = 1'b0;
        repeat (8) @(negedge clk);
        // R6: low register keeps the byte from the last high read
        rd(1'b1, d); check("R6", d, last_lo);
        rd(1'b1, d); check("R6", d, last_lo);
        rd(1'b0, d); check("R5", d, 8'h00);
        rd(1'b1, d); check("R6", d, 8'(exp_cnt(30)));
        // R9: writes to the low address are ignored
        wr(1'b1, 8'hFF);
        rd(1'b1, d); check("R9", d, 8'(exp_cnt(30)));
        check("R9", {6'd0, clamp_width}, 8'h00);
        // R8: clamp field from bits 6:5, read-only bits untouched
        wr(1'b0, 8'hFF);
        check("R8", {6'd0, clamp_width}, 8'h03);
        rd(1'b0, d); check("R8", d, 8'h00);
        wr(1'b0, 8'h40);
        check("R8", {6'd0, clamp_width}, 8'h02);
        wr(1'b0, 8'h20);
        check("R8", {6'd0, clamp_width}, 8'h01);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1", {6'd0, clamp_width}, 8'h00);
        rd(1'b0, d); check("R1", d, 8'h00);
        rd(1'b1, d); check("R1", d, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule